// File: doc/BRIEF.md
# Dual-Slot Context Submission Tracker

This block follows the submission and retirement of execution contexts on one engine. Software-side logic hands it a pair of context descriptors to schedule in, or names a context that has finished. The block owns two submission slots, and each slot holds two descriptors. It records which slot is running, whether the other slot waits as pending, and which descriptor of the running slot is the live context. It keeps a 64-bit status word up to date and produces 64-bit context-status event words. A later stage stores those words and raises the interrupt.

Each request is classified by matching descriptor identities. A submission is either rejected, starts an idle engine (START), preempts the running slot with a lite restore (PREEMPT), or waits as pending (QUEUE). A completion is either rejected, moves to the second element of the running slot (ELEM_SW), or retires the slot (RETIRE) and promotes any pending one.

The controller has two FSM states. In IDLE it accepts a request, and it returns to IDLE through the "single" transition. A RETIRE with a pending slot takes the "chain" transition to SECOND, where it emits the follow-up event. SECOND always returns to IDLE through the "drain" transition. `req_ready` is high only in IDLE.

Top module: `exec_slot_ctrl`

## Requirements
- R1: Two descriptors name the same context only when both the 16-bit ID and the 16-bit address match. A completion whose ID matches the running context but whose address differs is an error.
- R2: A submission is rejected (`req_err` pulses, no event, status unchanged) when descriptor 0 is invalid, or when any valid descriptor has `priv` low.
- R3: A submission goes to the slot named by status bit 5 (write pointer). It is rejected when status bit 6 (queue full) is set.
- R4: With nothing running, an accepted submission makes its slot run with descriptor 0 as the live context, and emits one event with bit 0 (idle-to-active) set and ID 0.
- R5: While a slot runs, a submission preempts at once in two cases. The first is when running descriptor 1 is valid, matches new descriptor 0, and descriptor 0 is no longer the live context. The second is when running descriptor 1 is invalid and running descriptor 0 matches new descriptor 0. The event sets bits 5 (lite restore) and 1 (preempted) and carries the ID of new descriptor 0.
- R6: Any other accepted submission while running becomes pending. No event is emitted and status bit 6 is set.
- R7: A completion is an error (`req_err` pulses, no event) when nothing runs or when the named context is not the live one.
- R8: Completion of descriptor 0 while descriptor 1 is valid makes descriptor 1 live. It emits an event with bits 4 (complete) and 2 (element switch) and the finished ID.
- R9: Completion of the last element emits bits 4 and 3 (active-to-idle) with the finished ID. If a slot was pending, that slot starts running, the event has `ev_defer` set, and `req_ready` stays low for that cycle. In the next cycle an undeferred event follows with bit 0 set and ID 0.
- R10: Status layout: bits 0 and 1 are set while slot 0 runs, and bits 2 and 3 while slot 1 runs. Bit 4 is the running slot index and bit 5 is its inverse. Bit 6 means a slot is pending. Bits 47:32 hold the live context ID, or 0 when idle. When idle, bits 4 and 5 keep their last values.
- R11: Event outputs and `req_err` appear in the cycle after the accepting edge, for one cycle. The status word is already updated in that cycle. Event ID is at bits 47:32.
- R12: Reset clears slots, run and pending state, status and outputs, and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 = submission, 1 = completion |
| req_ready | output | 1 | Request accepted this cycle when high |
| d0_valid | input | 1 | Descriptor 0 valid |
| d0_priv | input | 1 | Descriptor 0 privilege-access bit |
| d0_id | input | 16 | Descriptor 0 ID; finished context ID for completions |
| d0_addr | input | 16 | Descriptor 0 address; finished context address for completions |
| d1_valid | input | 1 | Descriptor 1 valid |
| d1_priv | input | 1 | Descriptor 1 privilege-access bit |
| d1_id | input | 16 | Descriptor 1 ID |
| d1_addr | input | 16 | Descriptor 1 address |
| req_err | output | 1 | Request refused |
| ev_valid | output | 1 | Event word present |
| ev_word | output | 64 | Context-status event |
| ev_defer | output | 1 | Interrupt for this event is deferred |
| status | output | 64 | Status word |

## Verification
A wrong live-context selector or a wrong running index shows up in the status ID field and element bits in the cycle after the accepting edge. It also shows in the next completion, which is then wrongly rejected or misclassified. A lost pending flag shows as a missing deferred event and a missing idle-to-active follow-up, or as a queue-full rejection that never happens. The request sequence walks both slots, so a pointer that fails to hold while idle sends a later submission to the wrong slot, and the status word exposes that at once.

// File: rtl/exl_pkg.sv
package exl_pkg;
    localparam int ID_W   = 16;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 64;
    localparam int FLD_ID = 32;

    // status word bit positions
    localparam int ST_E0V = 0;
    localparam int ST_E0A = 1;
    localparam int ST_E1V = 2;
    localparam int ST_E1A = 3;
    localparam int ST_CUR = 4;
    localparam int ST_WP  = 5;
    localparam int ST_QF  = 6;

    // event word bit positions
    localparam int EV_I2A  = 0;
    localparam int EV_PRE  = 1;
    localparam int EV_ESW  = 2;
    localparam int EV_A2I  = 3;
    localparam int EV_CPL  = 4;
    localparam int EV_LITE = 5;

    typedef struct packed {
        logic              valid;
        logic              priv;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
    } desc_t;

    typedef enum logic [2:0] {
        ACT_REJECT, ACT_START, ACT_PREEMPT, ACT_QUEUE, ACT_ELEM_SW, ACT_RETIRE
    } act_e;

    typedef enum logic {ST_IDLE, ST_SECOND} fsm_e;

    function automatic logic same_ctx(desc_t a, desc_t b);
        return (a.id == b.id) && (a.addr == b.addr);
    endfunction

    function automatic logic [WORD_W-1:0] mk_ev(logic [5:0] flags, logic [ID_W-1:0] id);
        logic [WORD_W-1:0] w;
        w = '0;
        w[5:0] = flags;
        w[FLD_ID +: ID_W] = id;
        return w;
    endfunction
endpackage

// File: rtl/exl_classifier.sv
module exl_classifier
    import exl_pkg::*;
(
    input  logic  kind,
    input  desc_t n0,
    input  desc_t n1,
    input  desc_t r0,
    input  desc_t r1,
    input  logic  run_vld,
    input  logic  run_sel,
    input  logic  pend_vld,
    output act_e  act
);
    desc_t live;
    logic  bad_sub;

    always_comb begin
        live    = run_sel ? r1 : r0;
        bad_sub = !n0.valid || !n0.priv || (n1.valid && !n1.priv) || pend_vld;
        act     = ACT_REJECT;
        if (!kind) begin
            if (bad_sub)
                act = ACT_REJECT;
            else if (!run_vld)
                act = ACT_START;
            else if ((r1.valid && same_ctx(r1, n0) && !same_ctx(r0, live)) ||
                     (!r1.valid && same_ctx(r0, n0)))
                act = ACT_PREEMPT;
            else
                act = ACT_QUEUE;
        end else begin
            if (!run_vld || !same_ctx(n0, live))
                act = ACT_REJECT;
            else if (r1.valid && same_ctx(r0, n0))
                act = ACT_ELEM_SW;
            else if ((!r1.valid && same_ctx(r0, n0)) || (r1.valid && same_ctx(r1, n0)))
                act = ACT_RETIRE;
            else
                act = ACT_REJECT;
        end
    end
endmodule

// File: rtl/exl_status_reg.sv
module exl_status_reg
    import exl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic               run_vld,
    input  logic               run_idx,
    input  logic               pend_vld,
    input  logic [ID_W-1:0]    ctx_id,
    output logic [WORD_W-1:0]  st_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (upd) begin
            st_q[ST_QF] <= pend_vld;
            if (run_vld) begin
                st_q[ST_CUR] <= run_idx;
                st_q[ST_WP]  <= ~run_idx;
                st_q[ST_E0V] <= ~run_idx;
                st_q[ST_E0A] <= ~run_idx;
                st_q[ST_E1V] <= run_idx;
                st_q[ST_E1A] <= run_idx;
                st_q[FLD_ID +: ID_W] <= ctx_id;
            end else begin
                st_q[ST_E0V] <= 1'b0;
                st_q[ST_E0A] <= 1'b0;
                st_q[ST_E1V] <= 1'b0;
                st_q[ST_E1A] <= 1'b0;
                st_q[FLD_ID +: ID_W] <= '0;
            end
        end
    end

    // R10
    one_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q[ST_E0A], st_q[ST_E1A]}));
    // R10
    qf_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[ST_QF] |-> (st_q[ST_E0A] || st_q[ST_E1A]));
    // R10
    ptr_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[ST_E0A] || st_q[ST_E1A]) |-> (st_q[ST_CUR] != st_q[ST_WP]));
endmodule

// File: rtl/exec_slot_ctrl.sv
module exec_slot_ctrl
    import exl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_kind,
    output logic                 req_ready,
    input  logic                 d0_valid,
    input  logic                 d0_priv,
    input  logic [ID_W-1:0]      d0_id,
    input  logic [ADDR_W-1:0]    d0_addr,
    input  logic                 d1_valid,
    input  logic                 d1_priv,
    input  logic [ID_W-1:0]      d1_id,
    input  logic [ADDR_W-1:0]    d1_addr,
    output logic                 req_err,
    output logic                 ev_valid,
    output logic [WORD_W-1:0]    ev_word,
    output logic                 ev_defer,
    output logic [WORD_W-1:0]    status
);
    localparam int NSLOT = 2;
    localparam int NELEM = 2;

    fsm_e  state_q, state_d;
    desc_t slot_q [NSLOT][NELEM];
    logic  run_vld_q, run_idx_q, run_sel_q, pend_vld_q;
    logic  run_vld_d, run_idx_d, run_sel_d, pend_vld_d;
    desc_t n0, n1, r0, r1;
    act_e  act;
    logic  accept, wr_ptr, slot_we;
    logic [ID_W-1:0] ctx_id_d;

    assign n0        = '{valid: d0_valid, priv: d0_priv, id: d0_id, addr: d0_addr};
    assign n1        = '{valid: d1_valid, priv: d1_priv, id: d1_id, addr: d1_addr};
    assign r0        = slot_q[run_idx_q][0];
    assign r1        = slot_q[run_idx_q][1];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_ptr    = status[ST_WP];

    exl_classifier u_cls (
        .kind(req_kind), .n0(n0), .n1(n1), .r0(r0), .r1(r1),
        .run_vld(run_vld_q), .run_sel(run_sel_q), .pend_vld(pend_vld_q), .act(act)
    );

    always_comb begin
        run_vld_d  = run_vld_q;
        run_idx_d  = run_idx_q;
        run_sel_d  = run_sel_q;
        pend_vld_d = pend_vld_q;
        slot_we    = 1'b0;
        if (accept) begin
            unique case (act)
                ACT_START:   begin slot_we = 1'b1; run_vld_d = 1'b1; run_idx_d = wr_ptr; run_sel_d = 1'b0; end
                ACT_PREEMPT: begin slot_we = 1'b1; run_idx_d = wr_ptr; run_sel_d = 1'b0; pend_vld_d = 1'b0; end
                ACT_QUEUE:   begin slot_we = 1'b1; pend_vld_d = 1'b1; end
                ACT_ELEM_SW: run_sel_d = 1'b1;
                ACT_RETIRE: begin
                    run_sel_d = 1'b0;
                    if (pend_vld_q) begin
                        run_idx_d  = ~run_idx_q;
                        pend_vld_d = 1'b0;
                    end else begin
                        run_vld_d = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (slot_we && (act != ACT_QUEUE))
            ctx_id_d = n0.id;
        else
            ctx_id_d = slot_q[run_idx_d][run_sel_d].id;
    end

    // state transitions: single (IDLE->IDLE), chain (IDLE->SECOND), drain (SECOND->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && act == ACT_RETIRE && pend_vld_q) state_d = ST_SECOND;
            ST_SECOND: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_vld_q  <= 1'b0;
            run_idx_q  <= 1'b0;
            run_sel_q  <= 1'b0;
            pend_vld_q <= 1'b0;
            for (int s = 0; s < NSLOT; s++)
                for (int e = 0; e < NELEM; e++)
                    slot_q[s][e] <= '0;
        end else begin
            run_vld_q  <= run_vld_d;
            run_idx_q  <= run_idx_d;
            run_sel_q  <= run_sel_d;
            pend_vld_q <= pend_vld_d;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_we && (wr_ptr == s[0])) begin
                    slot_q[s][0] <= n0;
                    slot_q[s][1] <= n1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_word  <= '0;
            ev_defer <= 1'b0;
            req_err  <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            ev_defer <= 1'b0;
            req_err  <= 1'b0;
            if (state_q == ST_SECOND) begin
                ev_valid <= 1'b1;
                ev_word  <= mk_ev(6'(1 << EV_I2A), '0);
            end else if (accept) begin
                unique case (act)
                    ACT_REJECT:  req_err <= 1'b1;
                    ACT_START:   begin ev_valid <= 1'b1; ev_word <= mk_ev(6'(1 << EV_I2A), '0); end
                    ACT_PREEMPT: begin ev_valid <= 1'b1; ev_word <= mk_ev(6'((1 << EV_LITE) | (1 << EV_PRE)), n0.id); end
                    ACT_ELEM_SW: begin ev_valid <= 1'b1; ev_word <= mk_ev(6'((1 << EV_CPL) | (1 << EV_ESW)), n0.id); end
                    ACT_RETIRE: begin
                        ev_valid <= 1'b1;
                        ev_defer <= pend_vld_q;
                        ev_word  <= mk_ev(6'((1 << EV_CPL) | (1 << EV_A2I)), n0.id);
                    end
                    default: ;
                endcase
            end
        end
    end

    exl_status_reg u_st (
        .clk(clk), .rst_n(rst_n), .upd(accept),
        .run_vld(run_vld_d), .run_idx(run_idx_d), .pend_vld(pend_vld_d),
        .ctx_id(ctx_id_d), .st_q(status)
    );

    // R9
    defer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_defer) |=> (ev_valid && !ev_defer && ev_word[5:0] == 6'b000001
                                    && ev_word[FLD_ID +: ID_W] == '0));
    // R9
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_defer) |-> !req_ready);
    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_err && ev_valid));
    // R6
    queue_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_QF]) |-> !ev_valid);
endmodule

// File: tb/test_exec_slot_ctrl.sv
`timescale 1ns/1ps
module test_exec_slot_ctrl;
    import exl_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0;
    logic req_ready, req_err, ev_valid, ev_defer;
    desc_t q0 = '0, q1 = '0;
    logic [63:0] ev_word, status;

    always #2.5 clk = ~clk;

    exec_slot_ctrl i_exec_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(req_ready),
        .d0_valid(q0.valid), .d0_priv(q0.priv), .d0_id(q0.id), .d0_addr(q0.addr),
        .d1_valid(q1.valid), .d1_priv(q1.priv), .d1_id(q1.id), .d1_addr(q1.addr),
        .req_err(req_err), .ev_valid(ev_valid), .ev_word(ev_word),
        .ev_defer(ev_defer), .status(status)
    );

    typedef struct packed {
        logic        kind;
        desc_t       d0;
        desc_t       d1;
        logic        xerr;
        logic [1:0]  nev;
        logic [63:0] ev0;
        logic        df0;
        logic [63:0] ev1;
        logic [63:0] st;
        logic [7:0]  rq;
    } vec_t;

    localparam desc_t DN   = '0;
    localparam desc_t DX   = '{1'b1, 1'b1, 16'h0011, 16'h0100};
    localparam desc_t DY   = '{1'b1, 1'b1, 16'h0022, 16'h0200};
    localparam desc_t DZ   = '{1'b1, 1'b1, 16'h0033, 16'h0300};
    localparam desc_t DW   = '{1'b1, 1'b1, 16'h0044, 16'h0400};
    localparam desc_t DWI  = '{1'b0, 1'b1, 16'h0044, 16'h0400};
    localparam desc_t DWNP = '{1'b1, 1'b0, 16'h0044, 16'h0400};
    localparam desc_t DYNP = '{1'b1, 1'b0, 16'h0022, 16'h0200};
    localparam desc_t DYB  = '{1'b1, 1'b1, 16'h0022, 16'h0999};

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, DX,  DN,   1'b0, 2'd1, 64'h0000_0000_0000_0001, 1'b0, 64'h0, 64'h0000_0011_0000_0023, 8'd4},  // R4
        '{1'b0, DX,  DN,   1'b0, 2'd1, 64'h0000_0011_0000_0022, 1'b0, 64'h0, 64'h0000_0011_0000_001C, 8'd5},  // R5 case two
        '{1'b0, DY,  DZ,   1'b0, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0011_0000_005C, 8'd6},  // R6
        '{1'b0, DW,  DN,   1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0011_0000_005C, 8'd3},  // R3 queue full
        '{1'b1, DX,  DN,   1'b0, 2'd2, 64'h0000_0011_0000_0018, 1'b1, 64'h1, 64'h0000_0022_0000_0023, 8'd9},  // R9 promote
        '{1'b1, DZ,  DN,   1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0022_0000_0023, 8'd7},  // R7
        '{1'b1, DY,  DN,   1'b0, 2'd1, 64'h0000_0022_0000_0014, 1'b0, 64'h0, 64'h0000_0033_0000_0023, 8'd8},  // R8
        '{1'b0, DZ,  DN,   1'b0, 2'd1, 64'h0000_0033_0000_0022, 1'b0, 64'h0, 64'h0000_0033_0000_001C, 8'd5},  // R5 case one
        '{1'b0, DWI, DN,   1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0033_0000_001C, 8'd2},  // R2 d0 invalid
        '{1'b0, DWNP, DN,  1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0033_0000_001C, 8'd2},  // R2 d0 no priv
        '{1'b0, DW,  DYNP, 1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0033_0000_001C, 8'd2},  // R2 d1 no priv
        '{1'b0, DW,  DN,   1'b0, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0033_0000_005C, 8'd6},  // R6
        '{1'b1, DZ,  DN,   1'b0, 2'd2, 64'h0000_0033_0000_0018, 1'b1, 64'h1, 64'h0000_0044_0000_0023, 8'd9},  // R9
        '{1'b1, DW,  DN,   1'b0, 2'd1, 64'h0000_0044_0000_0018, 1'b0, 64'h0, 64'h0000_0000_0000_0020, 8'd9},  // R9 no pending, R10 hold
        '{1'b1, DW,  DN,   1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0000_0000_0020, 8'd7},  // R7 idle
        '{1'b0, DY,  DN,   1'b0, 2'd1, 64'h0000_0000_0000_0001, 1'b0, 64'h0, 64'h0000_0022_0000_001C, 8'd10}, // R10 slot 1
        '{1'b1, DYB, DN,   1'b1, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0022_0000_001C, 8'd1},  // R1 addr differs
        '{1'b0, DYB, DN,   1'b0, 2'd0, 64'h0,                   1'b0, 64'h0, 64'h0000_0022_0000_005C, 8'd1}   // R1 no preempt
    };

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic apply(input vec_t v);
        string tg;
        tg = $sformatf("R%0d", v.rq);
        @(negedge clk);
        req_kind  = v.kind;
        q0        = v.d0;
        q1        = v.d1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({63'd0, req_err}, {63'd0, v.xerr}, {tg, " err"});          // R11 timing
        chk({63'd0, ev_valid}, {63'd0, v.nev != 2'd0}, {tg, " ev_valid"});
        chk(status, v.st, {tg, " status"});
        if (v.nev != 2'd0) begin
            chk(ev_word, v.ev0, {tg, " ev_word"});
            chk({63'd0, ev_defer}, {63'd0, v.df0}, {tg, " ev_defer"});
        end
        if (v.nev == 2'd2) begin
            chk({63'd0, req_ready}, 64'd0, {tg, " ready low on deferred"}); // R9
            @(negedge clk);
            chk({63'd0, ev_valid}, 64'd1, {tg, " second ev_valid"});
            chk(ev_word, v.ev1, {tg, " second ev_word"});
            chk({63'd0, ev_defer}, 64'd0, {tg, " second ev_defer"});
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(status, 64'h0, "R12 status after reset");
        chk({63'd0, req_ready}, 64'd1, "R12 ready after reset");
        chk({63'd0, ev_valid}, 64'd0, "R12 no event after reset");
        for (int i = 0; i < NV; i++) apply(VEC[i]);
        // R12 reset with a pending slot clears it; a new submission then starts slot 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status, 64'h0, "R12 status after mid-run reset");
        apply('{1'b0, DZ, DN, 1'b0, 2'd1, 64'h1, 1'b0, 64'h0, 64'h0000_0033_0000_0023, 8'd12});
        // R7 completion naming a stale element after reset
        apply('{1'b1, DX, DN, 1'b1, 2'd0, 64'h0, 1'b0, 64'h0, 64'h0000_0033_0000_0023, 8'd7});
        @(negedge clk);
        chk({63'd0, ev_valid}, 64'd0, "R11 event lasts one cycle");
        finish_run();
    end
endmodule